// File: doc/BRIEF.md
# Right-to-Left Montgomery Modular Exponentiator

This block raises a base to an exponent modulo an odd modulus, which is the arithmetic at the heart of RSA encryption and decryption. The operand width is a parameter and defaults to 128 bits. The exponent is walked from its least significant bit upward. Each step squares a running power of the base. When the current exponent bit is set, the same step also folds that power into an accumulator. The two products do not depend on each other, so the block starts them together on two bit-serial Montgomery multipliers.

Values enter the Montgomery domain through one multiplication by the constant 2^(2N) mod M, which the caller supplies. The base becomes base·2^N mod M, and the accumulator starts at 2^N mod M. These two entry products also run side by side. After the last exponent bit, a single multiplication by 1 brings the accumulator back to ordinary form. The caller loads the operands with a one-cycle start pulse and reads the result once the ready flag rises.

Top module: `modexp_r2l`

## Requirements
- R1: For an odd modulus M > 1, a base below M and dom_i = 2^(2N) mod M, result_o equals base^exp mod M once ready_o is high; a base of zero with a non-zero exponent gives zero.
- R2: An exponent of zero yields 1 (that is, 1 mod M for M > 1).
- R3: An exponent of one returns the base unchanged.
- R4: An exponent with every one of its N bits set is processed over all N bit positions and gives the correct power.
- R5: In the cycle after an accepted start, ready_o is low. Once ready_o rises, it stays high and result_o stays unchanged until the next start.
- R6: A start pulse that arrives while a computation is running has no effect, and the running computation finishes with its original operands.
- R7: The time from start to ready does not depend on the exponent's bit pattern. It is the same for an exponent of zero and for an exponent of all ones.
- R8: After reset, ready_o is low and result_o is zero.
- R9: Encrypting a message with a public exponent and then decrypting the result with the matching private exponent, under the same modulus, gives back the original message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads the operands; accepted only while idle or finished |
| base_i | input | N | Base; must be below mod_i |
| exp_i | input | N | Exponent |
| mod_i | input | N | Odd modulus |
| dom_i | input | N | Domain constant 2^(2N) mod M |
| result_o | output | N | base^exp mod M, valid while ready_o is high |
| ready_o | output | 1 | High from the end of a computation until the next accepted start |

## Verification
The bench builds the block with N = 32. At that width a 64-bit software model can compute every expected power, and each run finishes in about a thousand cycles. This lets the bench exercise large prime moduli, a textbook small RSA key pair for the round trip, and the exponent extremes of zero, one and all ones. The 32-bit exponent is still long enough for a mid-run start pulse to land well inside the loop, and for an exponent-dependent difference in latency to show up.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LOOP,
        ST_EXIT,
        ST_DONE
    } mexp_state_e;

endpackage

// File: rtl/mexp_montmul.sv
// Radix-2 bit-serial Montgomery multiplier: res = a*b*2^-N mod m.
// Latency: start sampled on one edge, result and done pulse N edges later.
module mexp_montmul #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [N-1:0] m_i,
    output logic         done_o,
    output logic [N-1:0] res_o
);
    localparam int W  = N + 2;
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic          busy;
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [N-1:0]  m;
        logic [W-1:0]  s;
        logic [CW-1:0] cnt;
        logic          done;
        logic [N-1:0]  res;
    } mm_regs_t;

    mm_regs_t mm_d, mm_q;

    always_comb begin
        logic [W-1:0] add_v;
        logic [W-1:0] sx_v;
        logic [W-1:0] sq_v;
        logic [W-1:0] sn_v;
        logic [W-1:0] red_v;
        mm_d      = mm_q;
        mm_d.done = 1'b0;
        add_v     = '0;
        sx_v      = '0;
        sq_v      = '0;
        sn_v      = '0;
        red_v     = '0;
        if (!mm_q.busy) begin
            if (start_i) begin
                mm_d.busy = 1'b1;
                mm_d.a    = a_i;
                mm_d.b    = b_i;
                mm_d.m    = m_i;
                mm_d.s    = '0;
                mm_d.cnt  = '0;
            end
        end else begin
            add_v    = mm_q.a[0] ? {2'b00, mm_q.b} : '0;
            sx_v     = mm_q.s + add_v;
            sq_v     = sx_v + (sx_v[0] ? {2'b00, mm_q.m} : '0);
            sn_v     = sq_v >> 1;
            mm_d.a   = mm_q.a >> 1;
            mm_d.s   = sn_v;
            mm_d.cnt = mm_q.cnt + 1'b1;
            if (mm_q.cnt == CW'(N - 1)) begin
                red_v     = (sn_v >= {2'b00, mm_q.m}) ? (sn_v - {2'b00, mm_q.m}) : sn_v;
                mm_d.busy = 1'b0;
                mm_d.done = 1'b1;
                mm_d.res  = red_v[N-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mm_q <= '0;
        else        mm_q <= mm_d;
    end

    assign done_o = mm_q.done;
    assign res_o  = mm_q.res;

    AST_MM_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        mm_q.done |-> (mm_q.res < mm_q.m)); // R1
    AST_MM_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mm_q.done |=> !mm_q.done); // R5
    AST_MM_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mm_q.busy |-> !start_i); // R6

endmodule

// File: rtl/mexp_scan.sv
// Exponent scanner: presents exponent bits LSB first and flags the last one.
module mexp_scan #(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] exp_i,
    input  logic         adv_i,
    output logic         bit_o,
    output logic         last_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  sh;
        logic [CW-1:0] cnt;
    } sc_regs_t;

    sc_regs_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (load_i) begin
            sc_d.sh  = exp_i;
            sc_d.cnt = '0;
        end else if (adv_i) begin
            sc_d.sh  = sc_q.sh >> 1;
            sc_d.cnt = sc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign bit_o  = sc_q.sh[0];
    assign last_o = (sc_q.cnt == CW'(N - 1));

    AST_SCAN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && last_o) |=> (load_i || !adv_i || sc_q.cnt == CW'(N - 1))); // R4

endmodule

// File: rtl/modexp_r2l.sv
module modexp_r2l
    import mexp_pkg::*;
#(
    parameter int N = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] base_i,
    input  logic [N-1:0] exp_i,
    input  logic [N-1:0] mod_i,
    input  logic [N-1:0] dom_i,
    output logic [N-1:0] result_o,
    output logic         ready_o
);
    localparam int NMUL = 2;
    localparam logic [N-1:0] ONE = N'(1);

    typedef struct packed {
        mexp_state_e  st;
        logic         launch;
        logic         pend0;
        logic         pend1;
        logic [N-1:0] base;
        logic [N-1:0] modv;
        logic [N-1:0] dom;
        logic [N-1:0] p;
        logic [N-1:0] r;
        logic [N-1:0] res;
        logic         ready;
    } top_regs_t;

    top_regs_t tp_d, tp_q;

    logic         mul_start [NMUL];
    logic [N-1:0] mul_a     [NMUL];
    logic [N-1:0] mul_b     [NMUL];
    logic         mul_done  [NMUL];
    logic [N-1:0] mul_res   [NMUL];
    logic         scan_load, scan_adv, scan_bit, scan_last;

    // Slot 0 squares (or maps the base in); slot 1 multiplies into the accumulator.
    always_comb begin
        mul_a[0] = (tp_q.st == ST_INIT) ? tp_q.dom  : tp_q.p;
        mul_b[0] = (tp_q.st == ST_INIT) ? tp_q.base : tp_q.p;
        mul_a[1] = (tp_q.st == ST_INIT) ? tp_q.dom  : ((tp_q.st == ST_EXIT) ? ONE    : tp_q.r);
        mul_b[1] = (tp_q.st == ST_INIT) ? ONE       : ((tp_q.st == ST_EXIT) ? tp_q.r : tp_q.p);
    end

    generate
        for (genvar g = 0; g < NMUL; g++) begin : g_mul
            mexp_montmul #(.N(N)) u_mul (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (mul_start[g]),
                .a_i     (mul_a[g]),
                .b_i     (mul_b[g]),
                .m_i     (tp_q.modv),
                .done_o  (mul_done[g]),
                .res_o   (mul_res[g])
            );
        end
    endgenerate

    mexp_scan #(.N(N)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (scan_load),
        .exp_i  (exp_i),
        .adv_i  (scan_adv),
        .bit_o  (scan_bit),
        .last_o (scan_last)
    );

    always_comb begin
        tp_d         = tp_q;
        mul_start[0] = 1'b0;
        mul_start[1] = 1'b0;
        scan_load    = 1'b0;
        scan_adv     = 1'b0;
        unique case (tp_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    tp_d.st     = ST_INIT;
                    tp_d.launch = 1'b1;
                    tp_d.ready  = 1'b0;
                    tp_d.base   = base_i;
                    tp_d.modv   = mod_i;
                    tp_d.dom    = dom_i;
                    scan_load   = 1'b1;
                end
            end
            ST_INIT: begin
                if (tp_q.launch) begin
                    mul_start[0] = 1'b1;
                    mul_start[1] = 1'b1;
                    tp_d.pend0   = 1'b1;
                    tp_d.pend1   = 1'b1;
                    tp_d.launch  = 1'b0;
                end else begin
                    if (mul_done[0]) begin
                        tp_d.p     = mul_res[0];
                        tp_d.pend0 = 1'b0;
                    end
                    if (mul_done[1]) begin
                        tp_d.r     = mul_res[1];
                        tp_d.pend1 = 1'b0;
                    end
                    if (!tp_q.pend0 && !tp_q.pend1) begin
                        tp_d.st     = ST_LOOP;
                        tp_d.launch = 1'b1;
                    end
                end
            end
            ST_LOOP: begin
                if (tp_q.launch) begin
                    mul_start[0] = 1'b1;
                    mul_start[1] = scan_bit;
                    tp_d.pend0   = 1'b1;
                    tp_d.pend1   = scan_bit;
                    tp_d.launch  = 1'b0;
                end else begin
                    if (mul_done[0]) begin
                        tp_d.p     = mul_res[0];
                        tp_d.pend0 = 1'b0;
                    end
                    if (mul_done[1]) begin
                        tp_d.r     = mul_res[1];
                        tp_d.pend1 = 1'b0;
                    end
                    if (!tp_q.pend0 && !tp_q.pend1) begin
                        scan_adv    = 1'b1;
                        tp_d.launch = 1'b1;
                        if (scan_last) tp_d.st = ST_EXIT;
                    end
                end
            end
            ST_EXIT: begin
                if (tp_q.launch) begin
                    mul_start[1] = 1'b1;
                    tp_d.pend1   = 1'b1;
                    tp_d.launch  = 1'b0;
                end else if (mul_done[1]) begin
                    tp_d.pend1 = 1'b0;
                    tp_d.res   = mul_res[1];
                    tp_d.ready = 1'b1;
                    tp_d.st    = ST_DONE;
                end
            end
            default: tp_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q    <= '0;
            tp_q.st <= ST_IDLE;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign result_o = tp_q.res;
    assign ready_o  = tp_q.ready;

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (tp_q.st == ST_IDLE || tp_q.st == ST_DONE)) |=> !ready_o); // R5
    AST_READY_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(result_o)); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && tp_q.st == ST_LOOP) |=> (tp_q.st != ST_INIT)); // R6
    AST_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (result_o < tp_q.modv)); // R1

endmodule

// File: tb/modexp_r2l_tb.sv
`timescale 1ns/1ps
module modexp_r2l_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [N-1:0] base_i = '0, exp_i = '0, mod_i = '0, dom_i = '0;
    logic [N-1:0] result_o;
    logic         ready_o;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic         rdy_prev = 1'b0;
    int           lat_zero, lat_ones, lat_tmp;
    logic [N-1:0] cipher;

    always #2.5 clk = ~clk;

    modexp_r2l #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i), .dom_i(dom_i),
        .result_o(result_o), .ready_o(ready_o)
    );

    function automatic longint unsigned mulmod(longint unsigned a, longint unsigned b, longint unsigned m);
        return (a * b) % m;
    endfunction

    function automatic longint unsigned powmod(longint unsigned b, longint unsigned e, longint unsigned m);
        longint unsigned acc = 1 % m;
        longint unsigned sq = b % m;
        for (int i = 0; i < N; i++) begin
            if (e[i]) acc = mulmod(acc, sq, m);
            sq = mulmod(sq, sq, m);
        end
        return acc;
    endfunction

    function automatic logic [N-1:0] domconst(longint unsigned m);
        longint unsigned r1 = (64'd1 << N) % m;
        return N'(mulmod(r1, r1, m));
    endfunction

    task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compares each new result against the scoreboard head.
    always @(negedge clk) begin
        if (ready_o && !rdy_prev && exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(result_o == e, t, result_o, e);
        end
        rdy_prev = ready_o;
    end

    task automatic launch(input logic [N-1:0] b, input logic [N-1:0] e, input logic [N-1:0] m);
        @(negedge clk);
        base_i = b; exp_i = e; mod_i = m; dom_i = domconst(m);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(ready_o == 1'b0, "R5 ready low after start", ready_o, 0);
    endtask

    task automatic wait_ready(output int lat);
        lat = 1;
        while (!ready_o) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic [N-1:0] b, input logic [N-1:0] e, input logic [N-1:0] m,
                          input string tag, output int lat);
        exp_q.push_back(N'(powmod(b, e, m)));
        tag_q.push_back(tag);
        launch(b, e, m);
        wait_ready(lat);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready_o == 1'b0, "R8 ready after reset", ready_o, 0);
        chk(result_o == '0, "R8 result after reset", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'h0123_4567, 32'h0001_0001, 32'hFFFF_FFFB, "R1 large prime modulus", lat_tmp);
        run_op(32'd999, 32'hDEAD_BEEF, 32'd1000003, "R1 mixed exponent", lat_tmp);
        run_op(32'd0, 32'd5, 32'hFFFF_FFFB, "R1 zero base", lat_tmp);
        run_op(32'h7654_3210, 32'd0, 32'hFFFF_FFFB, "R2 zero exponent", lat_zero);
        chk(result_o == 32'd1, "R2 result equals one", result_o, 1);
        run_op(32'h7654_3210, 32'hFFFF_FFFF, 32'hFFFF_FFFB, "R4 all-ones exponent", lat_ones);
        chk(lat_zero == lat_ones, "R7 latency independent of exponent", lat_ones, lat_zero);
        run_op(32'h00AB_CDEF, 32'd1, 32'h8000_0001, "R3 unit exponent", lat_tmp);
        chk(result_o == 32'h00AB_CDEF, "R3 base returned", result_o, 32'h00AB_CDEF);

        // R5: result and ready held while no start arrives
        lat_tmp = int'(result_o);
        repeat (6) @(negedge clk);
        chk(ready_o == 1'b1, "R5 ready held", ready_o, 1);
        chk(result_o == N'(lat_tmp), "R5 result held", result_o, lat_tmp);

        // R6: a start during a run is ignored
        exp_q.push_back(N'(powmod(32'd12345, 32'hCAFE_0001, 32'hFFFF_FFFB)));
        tag_q.push_back("R6 mid-run start ignored");
        launch(32'd12345, 32'hCAFE_0001, 32'hFFFF_FFFB);
        repeat (200) @(negedge clk);
        base_i = 32'd7; exp_i = 32'd3; mod_i = 32'd1000003; dom_i = domconst(32'd1000003);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_ready(lat_tmp);
        @(negedge clk);

        // R9: small RSA key pair (n = 61*53, e = 17, d = 2753)
        run_op(32'd65, 32'd17, 32'd3233, "R9 encrypt", lat_tmp);
        cipher = result_o;
        chk(cipher == 32'd2790, "R9 ciphertext value", cipher, 2790);
        run_op(cipher, 32'd2753, 32'd3233, "R9 decrypt", lat_tmp);
        chk(result_o == 32'd65, "R9 round trip message", result_o, 65);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule